// File: doc/BRIEF.md
# Eight-bit Arithmetic, Logic and Shift Unit

This block is the operation core of a small accumulator datapath. Each clock it takes two byte operands, a 4-bit operation code and a carry input. It produces a byte result and the four condition flags: negative (N), zero (Z), two's-complement overflow (V) and carry (C). It also drives one write-enable line per flag, so a surrounding condition register knows which flags the operation just changed.

Increment, decrement, the bitwise operations, complement, and the single-bit shifts and rotates are computed inside the block. Multiply and divide are only decoded here. The byte they return is taken from two external ports that an outside multiplier and divider drive.

The result, the flags and the write enables are captured in one register stage. Each flag keeps its previous value whenever the current operation does not update it, so a held flag can be seen directly at the ports.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, the result, all four flags and all four write enables are 0.
- R2: The outputs reflect the inputs present at a rising clock edge, one edge later; changing the inputs between edges does not change the outputs.
- R3: Code 0101 returns A+1 and code 0110 returns A-1, both modulo 256. N, Z and V are updated and C is held. V is set only for an increment of 0x7F or a decrement of 0x80.
- R4: Code 0111 (multiply) returns `mul_lo_in`. C is set to bit 7 of that byte, and N, Z and V are held.
- R5: Code 0100 (divide) returns `div_quo_in`. Z is updated, and N, V and C are held.
- R6: Codes 1000, 1001, 1010 and 1011 return A AND B, A OR B, NOT A and A XOR B. N and Z are updated, V is cleared and C is held.
- R7: Code 1100 shifts A right by one bit with a 0 entering bit 7. Code 1101 shifts A left by one bit with a 0 entering bit 0. C takes the bit shifted out.
- R8: Code 1110 rotates A right with `carry_in` entering bit 7. Code 1111 rotates A left with `carry_in` entering bit 0. C takes the bit rotated out.
- R9: For codes 1100 to 1111, all four flags are updated, and V equals N XOR C of the new values.
- R10: Whenever N or Z is updated, N equals bit 7 of the result and Z is 1 exactly when the result is 0x00.
- R11: Codes 0000 to 0011 return 0x00, hold all four flags and drive no write enable.
- R12: The write enables `wr_en_n`, `wr_en_z`, `wr_en_v` and `wr_en_c` are 1 for exactly the flags the operation updates, as listed in R3 to R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_a | input | 8 | First operand; the operand used by shifts, rotates, increment, decrement and complement |
| opnd_b | input | 8 | Second operand for the two-operand logic operations |
| op_sel | input | 4 | Operation code |
| carry_in | input | 1 | Bit entering the operand during a rotate |
| mul_lo_in | input | 8 | Low product byte from the external multiplier |
| div_quo_in | input | 8 | Quotient byte from the external divider |
| alu_result | output | 8 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| wr_en_n | output | 1 | N was updated by the last operation |
| wr_en_z | output | 1 | Z was updated by the last operation |
| wr_en_v | output | 1 | V was updated by the last operation |
| wr_en_c | output | 1 | C was updated by the last operation |

## Verification
The bench targets the signed boundaries of increment and decrement: 0x7F, 0x80, 0xFF and 0x00. A design that computed V from the carry, or in the wrong direction, would flag the wrong step or miss the wrap. It then runs logic, multiply and divide operations after a shift has left C at 1. A design that cleared or recomputed a held flag would lose that carry.

Rotates are driven with both carry-input values on operands whose end bits differ. A design that fed the old C flag in place of `carry_in`, or swapped the two directions, would put the wrong bit in bit 7 or bit 0. The four unlisted codes are sent while the flags hold non-zero values, which catches any design that produces a stray result or a write enable for them.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    // Operation codes (the encoding is fixed by the surrounding decoder)
    localparam logic [3:0] OP_DIV = 4'b0100;
    localparam logic [3:0] OP_INC = 4'b0101;
    localparam logic [3:0] OP_DEC = 4'b0110;
    localparam logic [3:0] OP_MUL = 4'b0111;
    localparam logic [3:0] OP_AND = 4'b1000;
    localparam logic [3:0] OP_OR  = 4'b1001;
    localparam logic [3:0] OP_COM = 4'b1010;
    localparam logic [3:0] OP_XOR = 4'b1011;
    localparam logic [3:0] OP_SHR = 4'b1100;
    localparam logic [3:0] OP_SHL = 4'b1101;
    localparam logic [3:0] OP_ROR = 4'b1110;
    localparam logic [3:0] OP_ROL = 4'b1111;

    // Operation class taken from the two upper code bits
    localparam logic [1:0] CLS_ARITH_LO = 2'b00;
    localparam logic [1:0] CLS_ARITH_HI = 2'b01;
    localparam logic [1:0] CLS_LOGIC    = 2'b10;
    localparam logic [1:0] CLS_SHIFT    = 2'b11;

    localparam int NUM_FLAGS = 4;

    // One bit per condition flag; used for values and for update masks
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flag_vec_t;

endpackage

// File: rtl/alu8_arith_unit.sv
module alu8_arith_unit
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [3:0]       sel_i,
    input  logic [WIDTH-1:0] mul_lo_i,
    input  logic [WIDTH-1:0] div_q_i,
    output logic [WIDTH-1:0] res_o,
    output flag_vec_t        flags_o,
    output flag_vec_t        upd_o
);

    localparam int MSB = WIDTH - 1;
    localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] MIN_NEG = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

    logic [WIDTH-1:0] res_d;
    logic             ovf_d;

    always_comb begin
        res_d = '0;
        ovf_d = 1'b0;
        upd_o = '0;
        unique case (sel_i)
            OP_INC: begin
                res_d = a_i + ONE;
                ovf_d = (a_i == MAX_POS);
                upd_o = '{n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b0};
            end
            OP_DEC: begin
                res_d = a_i - ONE;
                ovf_d = (a_i == MIN_NEG);
                upd_o = '{n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b0};
            end
            OP_MUL: begin
                res_d = mul_lo_i;
                upd_o = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b1};
            end
            OP_DIV: begin
                res_d = div_q_i;
                upd_o = '{n: 1'b0, z: 1'b1, v: 1'b0, c: 1'b0};
            end
            default: begin
                res_d = '0;
                upd_o = '0;
            end
        endcase
    end

    assign res_o      = res_d;
    assign flags_o.n  = res_d[MSB];
    assign flags_o.z  = (res_d == '0);
    assign flags_o.v  = ovf_d;
    assign flags_o.c  = mul_lo_i[MSB];

endmodule

// File: rtl/alu8_logic_unit.sv
module alu8_logic_unit
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       fn_i,
    output logic [WIDTH-1:0] res_o,
    output flag_vec_t        flags_o,
    output flag_vec_t        upd_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] res_d;

    always_comb begin
        unique case (fn_i)
            2'b00:   res_d = a_i & b_i;
            2'b01:   res_d = a_i | b_i;
            2'b10:   res_d = ~a_i;
            default: res_d = a_i ^ b_i;
        endcase
    end

    assign res_o     = res_d;
    assign flags_o.n = res_d[MSB];
    assign flags_o.z = (res_d == '0);
    assign flags_o.v = 1'b0;
    assign flags_o.c = 1'b0;
    assign upd_o     = '{n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b0};

endmodule

// File: rtl/alu8_shift_unit.sv
module alu8_shift_unit
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic             cin_i,
    input  logic [1:0]       fn_i,
    output logic [WIDTH-1:0] res_o,
    output flag_vec_t        flags_o,
    output flag_vec_t        upd_o
);

    localparam int MSB = WIDTH - 1;

    logic             is_left;
    logic             fill_bit;
    logic [WIDTH-1:0] res_d;
    logic             out_bit;

    // fn_i[1] selects rotate (fill from carry input), fn_i[0] selects left
    assign is_left  = fn_i[0];
    assign fill_bit = fn_i[1] ? cin_i : 1'b0;

    always_comb begin
        if (is_left) begin
            res_d   = {a_i[MSB-1:0], fill_bit};
            out_bit = a_i[MSB];
        end else begin
            res_d   = {fill_bit, a_i[MSB:1]};
            out_bit = a_i[0];
        end
    end

    assign res_o     = res_d;
    assign flags_o.n = res_d[MSB];
    assign flags_o.z = (res_d == '0);
    assign flags_o.c = out_bit;
    assign flags_o.v = res_d[MSB] ^ out_bit;
    assign upd_o     = '{n: 1'b1, z: 1'b1, v: 1'b1, c: 1'b1};

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [3:0]       op_sel,
    input  logic             carry_in,
    input  logic [WIDTH-1:0] mul_lo_in,
    input  logic [WIDTH-1:0] div_quo_in,
    output logic [WIDTH-1:0] alu_result,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_v,
    output logic             flag_c,
    output logic             wr_en_n,
    output logic             wr_en_z,
    output logic             wr_en_v,
    output logic             wr_en_c
);

    typedef struct packed {
        logic [WIDTH-1:0] res;
        flag_vec_t        flags;
        flag_vec_t        upd;
    } alu_state_t;

    logic [WIDTH-1:0] ar_res, lg_res, sh_res;
    flag_vec_t        ar_flags, lg_flags, sh_flags;
    flag_vec_t        ar_upd, lg_upd, sh_upd;

    logic [WIDTH-1:0]     sel_res;
    flag_vec_t            sel_flags;
    flag_vec_t            sel_upd;
    logic [NUM_FLAGS-1:0] merged_flags;

    alu_state_t st_d, st_q;

    alu8_arith_unit #(.WIDTH(WIDTH)) u_arith (
        .a_i      (opnd_a),
        .sel_i    (op_sel),
        .mul_lo_i (mul_lo_in),
        .div_q_i  (div_quo_in),
        .res_o    (ar_res),
        .flags_o  (ar_flags),
        .upd_o    (ar_upd)
    );

    alu8_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a_i     (opnd_a),
        .b_i     (opnd_b),
        .fn_i    (op_sel[1:0]),
        .res_o   (lg_res),
        .flags_o (lg_flags),
        .upd_o   (lg_upd)
    );

    alu8_shift_unit #(.WIDTH(WIDTH)) u_shift (
        .a_i     (opnd_a),
        .cin_i   (carry_in),
        .fn_i    (op_sel[1:0]),
        .res_o   (sh_res),
        .flags_o (sh_flags),
        .upd_o   (sh_upd)
    );

    // Pick the unit that owns this operation class
    always_comb begin
        unique case (op_sel[3:2])
            CLS_LOGIC: begin
                sel_res   = lg_res;
                sel_flags = lg_flags;
                sel_upd   = lg_upd;
            end
            CLS_SHIFT: begin
                sel_res   = sh_res;
                sel_flags = sh_flags;
                sel_upd   = sh_upd;
            end
            default: begin
                sel_res   = ar_res;
                sel_flags = ar_flags;
                sel_upd   = ar_upd;
            end
        endcase
    end

    // Per flag: take the new value if updated, otherwise keep the stored one
    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag_hold
        assign merged_flags[gi] = sel_upd[gi] ? sel_flags[gi] : st_q.flags[gi];
    end

    always_comb begin
        st_d       = st_q;
        st_d.res   = sel_res;
        st_d.flags = merged_flags;
        st_d.upd   = sel_upd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alu_result = st_q.res;
    assign flag_n     = st_q.flags.n;
    assign flag_z     = st_q.flags.z;
    assign flag_v     = st_q.flags.v;
    assign flag_c     = st_q.flags.c;
    assign wr_en_n    = st_q.upd.n;
    assign wr_en_z    = st_q.upd.z;
    assign wr_en_v    = st_q.upd.v;
    assign wr_en_c    = st_q.upd.c;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [3:0]       op_sel,
    input logic             carry_in,
    input logic [WIDTH-1:0] mul_lo_in,
    input logic [WIDTH-1:0] div_quo_in,
    input logic [WIDTH-1:0] alu_result,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_v,
    input logic             flag_c,
    input logic             wr_en_n,
    input logic             wr_en_z,
    input logic             wr_en_v,
    input logic             wr_en_c
);

    localparam int MSB = WIDTH - 1;

    logic is_logic, is_incdec, is_undef, is_mul;
    assign is_logic  = (op_sel[3:2] == 2'b10);
    assign is_incdec = (op_sel == 4'b0101) || (op_sel == 4'b0110);
    assign is_undef  = (op_sel[3:2] == 2'b00);
    assign is_mul    = (op_sel == 4'b0111);

    // R6
    logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic |=> (!flag_v && $stable(flag_c)));

    // R3
    incdec_carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_incdec |=> $stable(flag_c));

    // R11
    undef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_undef |=> (alu_result == '0 && $stable({flag_n, flag_z, flag_v, flag_c})
                      && !wr_en_n && !wr_en_z && !wr_en_v && !wr_en_c));

    // R4
    mul_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_mul |=> (flag_c == $past(mul_lo_in[MSB]) && $stable({flag_n, flag_z, flag_v})));

    // R10
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_z |-> (flag_z == (alu_result == '0)));

    // R10
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_n |-> (flag_n == alu_result[MSB]));

    // R9
    shift_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel[3:2] == 2'b11) |=> (flag_v == (flag_n ^ flag_c)));

endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/alu8_core_tb_top.sv
`timescale 1ns/1ps
module alu8_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] opnd_a, opnd_b, mul_lo_in, div_quo_in;
    logic [3:0] op_sel;
    logic       carry_in;
    logic [7:0] alu_result;
    logic       flag_n, flag_z, flag_v, flag_c;
    logic       wr_en_n, wr_en_z, wr_en_v, wr_en_c;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    int m_res = 0;
    int m_n = 0, m_z = 0, m_v = 0, m_c = 0;
    int m_we = 0;
    string m_tag = "R1";

    always #2.5 clk = ~clk;

    alu8_core dut_i (.*);

    function automatic string tag_of(int s);
        case (s)
            5, 6:          return "R3 R10 R12";
            7:             return "R4 R12";
            4:             return "R5 R10 R12";
            8, 9, 10, 11:  return "R6 R10 R12";
            12, 13:        return "R7 R9 R10 R12";
            14, 15:        return "R8 R9 R10 R12";
            default:       return "R11 R12";
        endcase
    endfunction

    task automatic model(int a, int b, int s, int ci, int ml, int dq);
        int r = 0;
        int un = 0, uz = 0, uv = 0, uc = 0;
        int nv = 0, nc = 0;
        case (s)
            5:  begin r = (a + 1) % 256;   un = 1; uz = 1; uv = 1; nv = (a == 127); end
            6:  begin r = (a + 255) % 256; un = 1; uz = 1; uv = 1; nv = (a == 128); end
            7:  begin r = ml; uc = 1; nc = (ml >= 128); end
            4:  begin r = dq; uz = 1; end
            8:  begin r = a & b;       un = 1; uz = 1; uv = 1; end
            9:  begin r = a | b;       un = 1; uz = 1; uv = 1; end
            10: begin r = 255 - a;     un = 1; uz = 1; uv = 1; end
            11: begin r = a ^ b;       un = 1; uz = 1; uv = 1; end
            12: begin r = a / 2;                      nc = a % 2; end
            13: begin r = (a * 2) % 256;              nc = a / 128; end
            14: begin r = ci * 128 + a / 2;           nc = a % 2; end
            15: begin r = (a * 2) % 256 + ci;         nc = a / 128; end
            default: r = 0;
        endcase
        if (s >= 12) begin
            un = 1; uz = 1; uv = 1; uc = 1;
            nv = (r / 128) ^ nc;
        end
        m_res = r;
        if (un) m_n = r / 128;
        if (uz) m_z = (r == 0);
        if (uv) m_v = nv;
        if (uc) m_c = nc;
        m_we  = un * 8 + uz * 4 + uv * 2 + uc;
        m_tag = tag_of(s);
    endtask

    task automatic compare(string tag);
        int got_f, exp_f, got_we;
        got_f  = {flag_n, flag_z, flag_v, flag_c};
        exp_f  = m_n * 8 + m_z * 4 + m_v * 2 + m_c;
        got_we = {wr_en_n, wr_en_z, wr_en_v, wr_en_c};
        n_cmp++;
        if (int'(alu_result) != m_res || got_f != exp_f || got_we != m_we) begin
            n_bad++;
            $display("FAIL %s: result/flags(NZVC)/we got %02h/%04b/%04b expected %02h/%04b/%04b",
                     tag, alu_result, got_f[3:0], got_we[3:0], m_res[7:0], exp_f[3:0], m_we[3:0]);
        end
    endtask

    task automatic step(int a, int b, int s, int ci, int ml, int dq);
        @(negedge clk);
        opnd_a = 8'(a); opnd_b = 8'(b); op_sel = 4'(s);
        carry_in = 1'(ci); mul_lo_in = 8'(ml); div_quo_in = 8'(dq);
        #0.5;
        // R2: nothing visible before the edge
        compare("R2");
        model(a, b, s, ci, ml, dq);
        @(posedge clk);
        #1;
        compare(m_tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        opnd_a = 8'h5A; opnd_b = 8'h3C; op_sel = 4'b0101;
        carry_in = 1'b1; mul_lo_in = 8'hFF; div_quo_in = 8'h11;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        compare("R1");
        @(negedge clk);
        rst_n = 1'b1;
        op_sel = 4'b0000;
        @(posedge clk);
        #1;
        compare("R11");

        // R3 boundaries
        step(8'h7F, 0, 5, 0, 0, 0);
        step(8'h80, 0, 6, 0, 0, 0);
        step(8'hFF, 0, 5, 0, 0, 0);
        step(8'h00, 0, 6, 0, 0, 0);
        step(8'h01, 0, 6, 0, 0, 0);
        // R7/R9: set C=1 then check holds
        step(8'h81, 0, 12, 1, 0, 0);
        step(8'hF0, 8'h0F, 8, 0, 0, 0);   // R6 AND -> zero, C held
        step(8'h12, 8'h40, 9, 0, 0, 0);
        step(8'h0F, 0, 10, 0, 0, 0);
        step(8'hAA, 8'hAA, 11, 0, 0, 0);
        step(8'h7F, 0, 5, 0, 0, 0);       // R3 C still held
        // R4 multiply
        step(0, 0, 7, 0, 8'h80, 0);
        step(0, 0, 7, 0, 8'h7F, 0);
        // R5 divide
        step(0, 0, 4, 0, 0, 8'h00);
        step(0, 0, 4, 0, 0, 8'h9C);
        // R7 shifts
        step(8'h80, 0, 13, 1, 0, 0);
        step(8'h01, 0, 12, 1, 0, 0);
        step(8'h40, 0, 13, 0, 0, 0);
        // R8 rotates
        step(8'h01, 0, 14, 1, 0, 0);
        step(8'h02, 0, 14, 1, 0, 0);
        step(8'h80, 0, 15, 0, 0, 0);
        step(8'h7F, 0, 15, 1, 0, 0);
        step(8'h00, 0, 14, 0, 0, 0);
        // R11 with non-zero flags held
        step(8'hFF, 0, 13, 0, 0, 0);
        for (int k = 0; k < 4; k++) step(8'hC3, 8'h3C, k, 1, 8'hAA, 8'h55);

        for (int i = 0; i < 2000; i++)
            step($urandom % 256, $urandom % 256, $urandom % 16,
                 $urandom % 2, $urandom % 256, $urandom % 256);

        // reset again mid-run (R1)
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        m_res = 0; m_n = 0; m_z = 0; m_v = 0; m_c = 0; m_we = 0;
        compare("R1");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule